// File: doc/BRIEF.md
# Dual-Channel Table-Driven DAC Code Controller

This block produces the 8-bit input codes for two DACs that share a single ADC. Each channel has its own 64-entry byte table. Each channel also picks one of three sources on its own: the ADC result used as the table index, a 6-bit index held in a control register, or a full control byte that skips the table. The ADC is common to both channels. Tables, select bits, index fields and direct bytes are separate per channel.

After reset, a start-up sequencer steps through a fixed order. It first waits for the control bits to be recalled, then enables the analog section, and then enables the ADC once the converter supply is good. Next, a filter watches the ADC results. Both DAC codes stay at 00h until the filter accepts a result. By default the filter needs several identical conversions in a row; a control bit reduces this to one. The first DAC load already obeys the channel select bits. A supply-good input that drops sends the sequencer back to its start and forces both codes to zero.

Top module: `dac_src_ctrl`

## Requirements
- R1: While rst_n is low and on release, dac0_code and dac1_code are 00h, dac0_upd and dac1_upd are 0, and analog_en and adc_en are 0.
- R2: The sequencer advances in a fixed order. It leaves its idle state one clock after vpor_ok is high. analog_en rises one clock after recall_done is sampled high while waiting for recall. adc_en rises one clock after vadc_ok is sampled high while analog_en is set.
- R3: Both DAC codes stay at 00h, with no update strobe, until the start-up filter accepts a conversion.
- R4: With the filter enabled, acceptance needs MATCH_N (4) consecutive adc_vld results with equal adc_data. A differing result restarts the run at a count of one, with that result as the new reference.
- R5: With the filter-off control bit at 1, the first adc_vld result after adc_en rises completes start-up.
- R6: A channel with ctl_direct[c]=0 and ctl_idx_sel[c]=0 outputs table c entry at the latest ADC result. Table 0 (tbl_sel=0) feeds dac0 and table 1 (tbl_sel=1) feeds dac1.
- R7: A channel with ctl_direct[c]=0 and ctl_idx_sel[c]=1 outputs table c entry at its 6-bit index field (ctl_idx0 or ctl_idx1).
- R8: A channel with ctl_direct[c]=1 outputs its byte field (ctl_byte0 or ctl_byte1), whatever ctl_idx_sel[c] is.
- R9: Each channel's source and output are independent of the other channel's select bits and fields.
- R10: After start-up, a code and its update strobe change one clock after an adc_vld or ctl_wr. A table write alone changes neither. A lookup in the same cycle as a write to the looked-up entry returns the old entry.
- R11: vpor_ok low in any state, or vadc_ok low once adc_en is set, returns the sequencer to idle on the next clock. This clears analog_en, adc_en, both codes, both strobes and the filter count.
- R12: The load that completes start-up uses the channel select bits and fields in force at that moment.
- R13: Control fields are captured only while ctl_wr is high. In the cycle of a write the new values already apply. Changes without ctl_wr have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vpor_ok | input | 1 | Main supply good level |
| vadc_ok | input | 1 | Converter supply good level |
| recall_done | input | 1 | Control bits recalled pulse |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_filt_off | input | 1 | 1: single conversion completes start-up |
| ctl_direct | input | 2 | Per channel: 1 selects direct byte |
| ctl_idx_sel | input | 2 | Per channel: 1 selects register index for table |
| ctl_idx0 | input | IDX_W | Channel 0 table index field |
| ctl_idx1 | input | IDX_W | Channel 1 table index field |
| ctl_byte0 | input | CODE_W | Channel 0 direct byte |
| ctl_byte1 | input | CODE_W | Channel 1 direct byte |
| adc_vld | input | 1 | ADC result valid |
| adc_data | input | IDX_W | ADC result |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | Table select: 0 channel 0, 1 channel 1 |
| tbl_addr | input | IDX_W | Table write address |
| tbl_wdata | input | CODE_W | Table write data |
| analog_en | output | 1 | Analog section enable |
| adc_en | output | 1 | ADC enable |
| dac0_code | output | CODE_W | DAC 0 input code |
| dac0_upd | output | 1 | DAC 0 code loaded this cycle |
| dac1_code | output | CODE_W | DAC 1 input code |
| dac1_upd | output | 1 | DAC 1 code loaded this cycle |

## Verification
A wrong sequencer state shows at analog_en and adc_en within one clock. A filter count that is wrong shows as codes that leave 00h one conversion too early or too late. A wrong captured control field or ADC register shows at the next strobe: dac0_code or dac1_code comes from the wrong table entry or the wrong byte. A bad table entry stays hidden until a load reads that address. The bench therefore reads targeted entries after writes and exercises same-cycle write and lookup.

// File: rtl/dac_src_ctrl.sv
module dac_src_ctrl #(
  parameter int IDX_W   = 6,
  parameter int CODE_W  = 8,
  parameter int MATCH_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vpor_ok,
  input  logic              vadc_ok,
  input  logic              recall_done,
  input  logic              ctl_wr,
  input  logic              ctl_filt_off,
  input  logic [1:0]        ctl_direct,
  input  logic [1:0]        ctl_idx_sel,
  input  logic [IDX_W-1:0]  ctl_idx0,
  input  logic [IDX_W-1:0]  ctl_idx1,
  input  logic [CODE_W-1:0] ctl_byte0,
  input  logic [CODE_W-1:0] ctl_byte1,
  input  logic              adc_vld,
  input  logic [IDX_W-1:0]  adc_data,
  input  logic              tbl_we,
  input  logic              tbl_sel,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [CODE_W-1:0] tbl_wdata,
  output logic              analog_en,
  output logic              adc_en,
  output logic [CODE_W-1:0] dac0_code,
  output logic              dac0_upd,
  output logic [CODE_W-1:0] dac1_code,
  output logic              dac1_upd
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int CNT_W = $clog2(MATCH_N + 1);

  typedef enum logic [2:0] {S_IDLE, S_RECALL, S_ANALOG, S_FILTER, S_RUN} seq_t;

  seq_t              state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  ref_q;
  logic [IDX_W-1:0]  adc_q;
  logic              fo_q;
  logic [1:0]        dir_q, isel_q;
  logic [IDX_W-1:0]  idx0_q, idx1_q;
  logic [CODE_W-1:0] byte0_q, byte1_q;
  logic [CODE_W-1:0] tbl0 [DEPTH];
  logic [CODE_W-1:0] tbl1 [DEPTH];

  wire              fo_n    = ctl_wr ? ctl_filt_off : fo_q;
  wire [1:0]        dir_n   = ctl_wr ? ctl_direct   : dir_q;
  wire [1:0]        isel_n  = ctl_wr ? ctl_idx_sel  : isel_q;
  wire [IDX_W-1:0]  idx0_n  = ctl_wr ? ctl_idx0     : idx0_q;
  wire [IDX_W-1:0]  idx1_n  = ctl_wr ? ctl_idx1     : idx1_q;
  wire [CODE_W-1:0] byte0_n = ctl_wr ? ctl_byte0    : byte0_q;
  wire [CODE_W-1:0] byte1_n = ctl_wr ? ctl_byte1    : byte1_q;
  wire [IDX_W-1:0]  adc_n   = adc_vld ? adc_data    : adc_q;

  wire [IDX_W-1:0]  lk0  = isel_n[0] ? idx0_n : adc_n;
  wire [IDX_W-1:0]  lk1  = isel_n[1] ? idx1_n : adc_n;
  wire [CODE_W-1:0] src0 = dir_n[0] ? byte0_n : tbl0[lk0];
  wire [CODE_W-1:0] src1 = dir_n[1] ? byte1_n : tbl1[lk1];

  wire              live     = (state_q == S_FILTER) || (state_q == S_RUN);
  wire              pwr_fail = !vpor_ok || (!vadc_ok && live);
  wire              same     = (cnt_q != '0) && (adc_data == ref_q);
  wire [CNT_W-1:0]  cnt_nx   = same ? cnt_q + 1'b1 : CNT_W'(1);
  wire              accept   = (state_q == S_FILTER) && adc_vld &&
                               (fo_n || cnt_nx >= CNT_W'(MATCH_N));
  wire              load     = accept || ((state_q == S_RUN) && (adc_vld || ctl_wr));

  assign analog_en = (state_q == S_ANALOG) || live;
  assign adc_en    = live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fo_q    <= 1'b0;
      dir_q   <= '0;
      isel_q  <= '0;
      idx0_q  <= '0;
      idx1_q  <= '0;
      byte0_q <= '0;
      byte1_q <= '0;
      adc_q   <= '0;
    end else begin
      fo_q    <= fo_n;
      dir_q   <= dir_n;
      isel_q  <= isel_n;
      idx0_q  <= idx0_n;
      idx1_q  <= idx1_n;
      byte0_q <= byte0_n;
      byte1_q <= byte1_n;
      adc_q   <= adc_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        tbl0[i] <= '0;
        tbl1[i] <= '0;
      end
    end else if (tbl_we) begin
      if (tbl_sel) tbl1[tbl_addr] <= tbl_wdata;
      else         tbl0[tbl_addr] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      ref_q   <= '0;
    end else if (pwr_fail) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE:   state_q <= S_RECALL;
        S_RECALL: if (recall_done) state_q <= S_ANALOG;
        S_ANALOG: if (vadc_ok) state_q <= S_FILTER;
        S_FILTER: if (adc_vld) begin
          if (accept) begin
            state_q <= S_RUN;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_nx;
            ref_q <= adc_data;
          end
        end
        default:  state_q <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac0_code <= '0;
      dac1_code <= '0;
      dac0_upd  <= 1'b0;
      dac1_upd  <= 1'b0;
    end else if (pwr_fail) begin
      dac0_code <= '0;
      dac1_code <= '0;
      dac0_upd  <= 1'b0;
      dac1_upd  <= 1'b0;
    end else begin
      dac0_upd <= load;
      dac1_upd <= load;
      if (load) begin
        dac0_code <= src0;
        dac1_code <= src1;
      end
    end
  end

endmodule

// File: rtl/dac_src_chk.sv
module dac_src_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vpor_ok,
  input logic              vadc_ok,
  input logic              ctl_wr,
  input logic [1:0]        ctl_direct,
  input logic [CODE_W-1:0] ctl_byte0,
  input logic              adc_vld,
  input logic              analog_en,
  input logic              adc_en,
  input logic [CODE_W-1:0] dac0_code,
  input logic              dac0_upd,
  input logic [CODE_W-1:0] dac1_code,
  input logic              dac1_upd
);

  assert_codes_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |-> (dac0_code == '0 && dac1_code == '0 && !dac0_upd && !dac1_upd));

  assert_adc_needs_analog_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |-> analog_en);

  assert_adc_en_after_ok_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_en) |-> $past(vadc_ok));

  assert_upd_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dac0_upd || dac1_upd) |-> $past(adc_vld || ctl_wr));

  assert_direct_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_direct[0]) |=> (!dac0_upd || dac0_code == $past(ctl_byte0)));

  assert_supply_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !vpor_ok |=> (!analog_en && !adc_en && dac0_code == '0 && dac1_code == '0));

endmodule

bind dac_src_ctrl dac_src_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .vpor_ok(vpor_ok), .vadc_ok(vadc_ok),
  .ctl_wr(ctl_wr), .ctl_direct(ctl_direct), .ctl_byte0(ctl_byte0),
  .adc_vld(adc_vld), .analog_en(analog_en), .adc_en(adc_en),
  .dac0_code(dac0_code), .dac0_upd(dac0_upd),
  .dac1_code(dac1_code), .dac1_upd(dac1_upd)
);

// File: tb/dac_src_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_src_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  logic vpor_ok = 0, vadc_ok = 0, recall_done = 0;
  logic ctl_wr = 0, ctl_filt_off = 0;
  logic [1:0] ctl_direct = 0, ctl_idx_sel = 0;
  logic [5:0] ctl_idx0 = 0, ctl_idx1 = 0;
  logic [7:0] ctl_byte0 = 0, ctl_byte1 = 0;
  logic adc_vld = 0;
  logic [5:0] adc_data = 0;
  logic tbl_we = 0, tbl_sel = 0;
  logic [5:0] tbl_addr = 0;
  logic [7:0] tbl_wdata = 0;
  logic analog_en, adc_en, dac0_upd, dac1_upd;
  logic [7:0] dac0_code, dac1_code;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dac_src_ctrl dut_i (.*);

  int m_st, m_cnt, m_ref, m_adc;
  bit m_fo;
  bit m_dir[2], m_isel[2];
  int m_idx[2], m_byt[2], m_code[2];
  bit m_upd[2];
  int m_tb[2][64];

  function automatic int f0(int a); return (a * 7 + 3) & 255; endfunction
  function automatic int f1(int a); return (200 - a * 3) & 255; endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ref = 0; m_adc = 0; m_fo = 0;
      for (int c = 0; c < 2; c++) begin
        m_dir[c] = 0; m_isel[c] = 0; m_idx[c] = 0; m_byt[c] = 0;
        m_code[c] = 0; m_upd[c] = 0;
        for (int a = 0; a < 64; a++) m_tb[c][a] = 0;
      end
    end else begin
      bit fail, ld, nfo;
      int nadc, nc;
      if (ctl_wr) begin
        m_fo = ctl_filt_off;
        m_dir[0] = ctl_direct[0]; m_dir[1] = ctl_direct[1];
        m_isel[0] = ctl_idx_sel[0]; m_isel[1] = ctl_idx_sel[1];
        m_idx[0] = ctl_idx0; m_idx[1] = ctl_idx1;
        m_byt[0] = ctl_byte0; m_byt[1] = ctl_byte1;
      end
      nfo = m_fo;
      nadc = adc_vld ? int'(adc_data) : m_adc;
      fail = !vpor_ok || (!vadc_ok && m_st >= 3);
      ld = 0;
      if (fail) begin
        m_st = 0; m_cnt = 0;
        for (int c = 0; c < 2; c++) begin m_code[c] = 0; m_upd[c] = 0; end
      end else begin
        case (m_st)
          0: m_st = 1;
          1: if (recall_done) m_st = 2;
          2: if (vadc_ok) m_st = 3;
          3: if (adc_vld) begin
               nc = (m_cnt > 0 && int'(adc_data) == m_ref) ? m_cnt + 1 : 1;
               if (nfo || nc >= 4) begin ld = 1; m_st = 4; m_cnt = 0; end
               else begin m_cnt = nc; m_ref = adc_data; end
             end
          default: ld = adc_vld || ctl_wr;
        endcase
        for (int c = 0; c < 2; c++) begin
          m_upd[c] = ld;
          if (ld) m_code[c] = m_dir[c] ? m_byt[c] : m_tb[c][m_isel[c] ? m_idx[c] : nadc];
        end
      end
      m_adc = nadc;
      if (tbl_we) m_tb[tbl_sel][tbl_addr] = tbl_wdata;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    string t;
    t = (m_st == 4) ? "R10" : "R3";
    chk({t, " dac0_code"}, dac0_code, m_code[0]);
    chk({t, " dac1_code"}, dac1_code, m_code[1]);
    chk({t, " dac0_upd"}, dac0_upd, m_upd[0]);
    chk({t, " dac1_upd"}, dac1_upd, m_upd[1]);
    chk("R2 analog_en", analog_en, m_st >= 2);
    chk("R2 adc_en", adc_en, m_st >= 3);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic wr_tbl(bit s, int a, int d);
    tbl_we = 1; tbl_sel = s; tbl_addr = a[5:0]; tbl_wdata = d[7:0];
    step(); tbl_we = 0;
  endtask

  task automatic set_ctl(bit fo, bit [1:0] dir, bit [1:0] isel, int i0, int i1, int b0, int b1);
    ctl_wr = 1; ctl_filt_off = fo; ctl_direct = dir; ctl_idx_sel = isel;
    ctl_idx0 = i0[5:0]; ctl_idx1 = i1[5:0]; ctl_byte0 = b0[7:0]; ctl_byte1 = b1[7:0];
    step(); ctl_wr = 0;
  endtask

  task automatic conv(int d);
    adc_vld = 1; adc_data = d[5:0]; step(); adc_vld = 0;
  endtask

  initial begin
    step(); step();
    chk("R1 dac0_code in reset", dac0_code, 0);
    chk("R1 analog_en in reset", analog_en, 0);
    rst_n = 1;
    step();
    chk("R1 dac1_code after release", dac1_code, 0);
    chk("R1 adc_en after release", adc_en, 0);
    for (int a = 0; a < 64; a++) begin wr_tbl(0, a, f0(a)); wr_tbl(1, a, f1(a)); end
    set_ctl(0, 2'b00, 2'b10, 0, 10, 0, 0);
    vpor_ok = 1; step(); step(); step();
    chk("R2 analog waits for recall", analog_en, 0);
    recall_done = 1; step(); recall_done = 0;
    chk("R2 analog_en after recall", analog_en, 1);
    chk("R2 adc_en waits for vadc_ok", adc_en, 0);
    conv(9);
    chk("R3 no load before adc_en", dac0_upd, 0);
    vadc_ok = 1; step();
    chk("R2 adc_en after vadc_ok", adc_en, 1);
    conv(5); conv(5); conv(7); conv(7); conv(7);
    chk("R4 mismatch restarts count", dac0_code, 0);
    chk("R3 codes held during filter", dac1_code, 0);
    conv(7);
    chk("R4 accept after four equal", dac0_code, f0(7));
    chk("R12 first load uses index select", dac1_code, f1(10));
    chk("R4 first strobe", dac0_upd, 1);
    step();
    chk("R10 strobe is one cycle", dac0_upd, 0);
    conv(20);
    chk("R6 adc index through table 0", dac0_code, f0(20));
    chk("R9 channel 1 keeps its index", dac1_code, f1(10));
    set_ctl(0, 2'b01, 2'b11, 40, 33, 'hA5, 0);
    chk("R8 direct byte, idx_sel ignored", dac0_code, 'hA5);
    chk("R7 register index through table 1", dac1_code, f1(33));
    ctl_byte0 = 'h11; ctl_direct = 2'b00; conv(3);
    chk("R13 fields ignored without ctl_wr", dac0_code, 'hA5);
    set_ctl(0, 2'b00, 2'b10, 0, 33, 0, 0);
    chk("R6 back to adc index", dac0_code, f0(3));
    wr_tbl(0, 3, 'h42);
    chk("R10 table write alone no strobe", dac0_upd, 0);
    chk("R10 table write alone no change", dac0_code, f0(3));
    tbl_we = 1; tbl_sel = 0; tbl_addr = 3; tbl_wdata = 'h99;
    adc_vld = 1; adc_data = 3; step(); tbl_we = 0; adc_vld = 0;
    chk("R10 same-cycle write reads old", dac0_code, 'h42);
    conv(3);
    chk("R10 new entry after write", dac0_code, 'h99);
    vadc_ok = 0; step();
    chk("R11 codes cleared on vadc drop", dac0_code, 0);
    chk("R11 adc_en cleared on vadc drop", adc_en, 0);
    step(); recall_done = 1; step(); recall_done = 0;
    vadc_ok = 1; step();
    set_ctl(1, 2'b10, 2'b00, 0, 0, 0, 'h3C);
    chk("R11 filter restarts with zero codes", dac0_code, 0);
    conv(9);
    chk("R5 single conversion with filter off", dac0_code, f0(9));
    chk("R9 channel 1 direct byte", dac1_code, 'h3C);
    vpor_ok = 0; step();
    chk("R11 vpor drop clears analog_en", analog_en, 0);
    chk("R11 vpor drop clears dac1", dac1_code, 0);
    vpor_ok = 1; step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule